// File: doc/BRIEF.md
# Masked Block-Write Graphics Memory

This block is a synthesizable behavioural model of a two-bank, 32-bit graphics memory core that supports three kinds of masked write. Each bank keeps its own bit-mask enable. A bit-level write mask register and a 32-bit color register sit beside the array. Writes are either single-column writes that take their data from the data pins, or block writes that fill an aligned group of eight columns from the color register. In a block write the data pins act as per-byte column selects.

One command is issued per clock on a simplified command bus: activate (sets the bank's bit-mask enable from the special-function flag), write (normal or block, chosen by the flag), read, and register load (the flag picks the mask or the color register). Reads return the addressed word one cycle later. The array is reduced to 2 banks x 4 rows x 16 columns. Refresh, precharge, latency and burst sequencing are not modelled.

Top module: `sgram_blockwr_top`

## Requirements
- R1: Command ACT (cmd_i=1) sets the bit-mask enable of bank bank_i to sf_i. The other bank's enable is unchanged.
- R2: On a normal write to a bank whose bit-mask enable is 1, data bit i is written only where mask bit i is 1. Bits whose mask bit is 0 keep their stored value.
- R3: Command LOAD (cmd_i=4) copies dq_i into the mask register when sf_i=0, or into the color register when sf_i=1. The other register is unchanged.
- R4: Command WR (cmd_i=2) with sf_i=0 writes dq_i to the word at bank_i, row_i, col_i.
- R5: WR with sf_i=1 is a single block access. It writes columns {col_i[3], 0..7}, ignores col_i[2:0], and leaves every other column unchanged.
- R6: In a block write, bit dq_i[8*b+c] = 1 enables byte b of block column c. Where the bit is 0, that byte keeps its stored value.
- R7: In a block write the stored data is the color register. When the bank's bit-mask enable is 1, that data is further masked bit by bit by the mask register.
- R8: byte_mask_i[b] = 1 blocks byte b (bits 8b+7..8b). This holds for normal writes and for all eight columns of a block write.
- R9: After reset both bit-mask enables are 0, the mask and color registers are 0, the array is 0, and rd_valid_o is 0.
- R10: A RD (cmd_i=3) puts the addressed word on rd_data_o with rd_valid_o=1 on the next cycle. rd_valid_o is 0 in a cycle after any other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | 0 NOP, 1 ACT, 2 WR, 3 RD, 4 LOAD |
| sf_i | input | 1 | Special-function flag |
| bank_i | input | 1 | Bank address |
| row_i | input | 2 | Row address |
| col_i | input | 4 | Column address |
| dq_i | input | 32 | Write data, register load value, or block column selects |
| byte_mask_i | input | 4 | Per-byte write block, 1 = blocked |
| rd_data_o | output | 32 | Read word |
| rd_valid_o | output | 1 | Read data valid |

## Verification
The bench reads the columns just inside and just outside a block. A design that did not force the low column bits to zero, or that wrote a burst, would show color data in a neighbouring group. Sparse column-select patterns place one select bit in different bytes. Swapping the byte and column roles of dq_i would land the color bytes in the wrong words. The bench enables the bit mask on one bank and then disables it, to catch a shared enable or a stale enable. This includes a block write, where forgetting the mask would store the full color word. A reset in mid-run must clear the enable and both registers, so a later write must land unmasked and a block write must store zeros.

// File: rtl/sgram_pkg.sv
package sgram_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned N_BANKS = 2;
  localparam int unsigned N_ROWS  = 4;
  localparam int unsigned N_COLS  = 16;
  localparam int unsigned BLK_COLS = 8;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_WR   = 3'd2,
    CMD_RD   = 3'd3,
    CMD_LOAD = 3'd4
  } cmd_e;
endpackage

// File: rtl/sgram_mode_regs.sv
module sgram_mode_regs #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_BANKS = 2,
  localparam int unsigned BNK_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               act_i,
  input  logic               load_i,
  input  logic               sf_i,
  input  logic [BNK_W-1:0]   bank_i,
  input  logic [DATA_W-1:0]  dq_i,
  output logic [N_BANKS-1:0] wpb_en_o,
  output logic [DATA_W-1:0]  mask_o,
  output logic [DATA_W-1:0]  color_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wpb_en_o <= '0;
      mask_o   <= '0;
      color_o  <= '0;
    end else begin
      if (act_i) wpb_en_o[bank_i] <= sf_i;
      if (load_i && !sf_i) mask_o  <= dq_i;
      if (load_i &&  sf_i) color_o <= dq_i;
    end
  end
endmodule

// File: rtl/sgram_write_mask.sv
module sgram_write_mask #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BLK_COLS = 8,
  localparam int unsigned N_BYTES = DATA_W / 8,
  localparam int unsigned BLK_W   = $clog2(BLK_COLS)
) (
  input  logic                            blk_i,
  input  logic                            wpb_i,
  input  logic [DATA_W-1:0]               mask_i,
  input  logic [DATA_W-1:0]               color_i,
  input  logic [DATA_W-1:0]               dq_i,
  input  logic [N_BYTES-1:0]              byte_mask_i,
  input  logic [BLK_W-1:0]                col_lo_i,
  output logic [BLK_COLS-1:0][DATA_W-1:0] col_en_o,
  output logic [DATA_W-1:0]               wdata_o
);
  logic [DATA_W-1:0] bit_keep;

  assign bit_keep = wpb_i ? mask_i : '1;
  assign wdata_o  = blk_i ? color_i : dq_i;

  // block: dq bit 8*b+c selects column c of byte b; normal: only the addressed column
  for (genvar k = 0; k < BLK_COLS; k++) begin : g_col
    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
      logic lane_sel;
      assign lane_sel = blk_i ? dq_i[b*8 + k] : (col_lo_i == BLK_W'(k));
      assign col_en_o[k][b*8 +: 8] = {8{lane_sel & ~byte_mask_i[b]}} & bit_keep[b*8 +: 8];
    end
  end
endmodule

// File: rtl/sgram_array.sv
module sgram_array #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_BANKS  = 2,
  parameter int unsigned N_ROWS   = 4,
  parameter int unsigned N_COLS   = 16,
  parameter int unsigned BLK_COLS = 8,
  localparam int unsigned BNK_W   = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
  localparam int unsigned ROW_W   = $clog2(N_ROWS),
  localparam int unsigned COL_W   = $clog2(N_COLS),
  localparam int unsigned BLK_W   = $clog2(BLK_COLS),
  localparam int unsigned ADDR_W  = BNK_W + ROW_W + COL_W,
  localparam int unsigned DEPTH   = 1 << ADDR_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  logic                            rd_i,
  input  logic [BNK_W-1:0]                bank_i,
  input  logic [ROW_W-1:0]                row_i,
  input  logic [COL_W-1:0]                col_i,
  input  logic [BLK_COLS-1:0][DATA_W-1:0] col_en_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rd_data_o,
  output logic                            rd_valid_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-BLK_W-1:0] grp_addr;

  assign grp_addr = {bank_i, row_i, col_i[COL_W-1:BLK_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_i;
      if (rd_i) rd_data_o <= mem[{bank_i, row_i, col_i}];
      if (wr_i) begin
        for (int k = 0; k < BLK_COLS; k++) begin
          mem[{grp_addr, BLK_W'(k)}] <= (mem[{grp_addr, BLK_W'(k)}] & ~col_en_i[k])
                                      | (wdata_i & col_en_i[k]);
        end
      end
    end
  end
endmodule

// File: rtl/sgram_blockwr_top.sv
module sgram_blockwr_top
  import sgram_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  cmd_i,
  input  logic        sf_i,
  input  logic        bank_i,
  input  logic [1:0]  row_i,
  input  logic [3:0]  col_i,
  input  logic [31:0] dq_i,
  input  logic [3:0]  byte_mask_i,
  output logic [31:0] rd_data_o,
  output logic        rd_valid_o
);
  localparam int unsigned BLK_W = $clog2(BLK_COLS);

  logic [N_BANKS-1:0]               wpb_en;
  logic [DATA_W-1:0]                mask_r, color_r, wdata;
  logic [BLK_COLS-1:0][DATA_W-1:0]  col_en;
  logic                             is_wr;

  assign is_wr = (cmd_i == CMD_WR);

  sgram_mode_regs #(.DATA_W(DATA_W), .N_BANKS(N_BANKS)) u_regs (
    .clk_i, .rst_ni,
    .act_i   (cmd_i == CMD_ACT),
    .load_i  (cmd_i == CMD_LOAD),
    .sf_i, .bank_i, .dq_i,
    .wpb_en_o(wpb_en),
    .mask_o  (mask_r),
    .color_o (color_r)
  );

  sgram_write_mask #(.DATA_W(DATA_W), .BLK_COLS(BLK_COLS)) u_wmask (
    .blk_i      (sf_i),
    .wpb_i      (wpb_en[bank_i]),
    .mask_i     (mask_r),
    .color_i    (color_r),
    .dq_i,
    .byte_mask_i,
    .col_lo_i   (col_i[BLK_W-1:0]),
    .col_en_o   (col_en),
    .wdata_o    (wdata)
  );

  sgram_array #(.DATA_W(DATA_W), .N_BANKS(N_BANKS), .N_ROWS(N_ROWS),
                .N_COLS(N_COLS), .BLK_COLS(BLK_COLS)) u_array (
    .clk_i, .rst_ni,
    .wr_i     (is_wr),
    .rd_i     (cmd_i == CMD_RD),
    .bank_i, .row_i, .col_i,
    .col_en_i (col_en),
    .wdata_i  (wdata),
    .rd_data_o,
    .rd_valid_o
  );
endmodule

// File: rtl/sgram_blockwr_chk.sv
module sgram_blockwr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  cmd_i,
  input logic        sf_i,
  input logic        bank_i,
  input logic [31:0] dq_i,
  input logic        rd_valid_o,
  input logic [1:0]  wpb_en,
  input logic [31:0] mask_r,
  input logic [31:0] color_r
);
  // R1
  act_sets_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1) |=> (wpb_en[$past(bank_i)] == $past(sf_i)));
  // R1
  act_other_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1) |=> (wpb_en[~$past(bank_i)] == $past(wpb_en[~bank_i])));
  // R3
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd4 && !sf_i) |=> (mask_r == $past(dq_i)) && $stable(color_r));
  // R3
  color_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd4 && sf_i) |=> (color_r == $past(dq_i)) && $stable(mask_r));
  // R10
  rd_valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd3) |=> rd_valid_o);
  // R10
  rd_valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != 3'd3) |=> !rd_valid_o);
endmodule

bind sgram_blockwr_top sgram_blockwr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .sf_i(sf_i), .bank_i(bank_i),
  .dq_i(dq_i), .rd_valid_o(rd_valid_o), .wpb_en(wpb_en), .mask_r(mask_r),
  .color_r(color_r)
);

// File: tb/sgram_blockwr_tb_top.sv
`timescale 1ns/1ps
module sgram_blockwr_tb_top;
  typedef struct packed {
    logic [2:0]  cmd;
    logic        sf;
    logic        bank;
    logic [1:0]  row;
    logic [3:0]  col;
    logic [31:0] dq;
    logic [3:0]  bm;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 34;
  // cmd: 1 ACT, 2 WR, 3 RD, 4 LOAD
  localparam vec_t VEC [NV] = '{
    '{3'd3,1'b0,1'b0,2'd0,4'd0, 32'h0,        4'h0,32'h0,        8'd9}, // R9 array clear
    '{3'd2,1'b0,1'b0,2'd0,4'd3, 32'hA5A51234, 4'h0,32'h0,        8'd4},
    '{3'd3,1'b0,1'b0,2'd0,4'd3, 32'h0,        4'h0,32'hA5A51234, 8'd4}, // R4
    '{3'd2,1'b0,1'b0,2'd0,4'd3, 32'hFFFFFFFF, 4'h5,32'h0,        8'd8},
    '{3'd3,1'b0,1'b0,2'd0,4'd3, 32'h0,        4'h0,32'hFFA5FF34, 8'd8}, // R8 normal
    '{3'd4,1'b1,1'b0,2'd0,4'd0, 32'hC0C1C2C3, 4'h0,32'h0,        8'd3},
    '{3'd2,1'b1,1'b1,2'd2,4'd13,32'hFFFFFFFF, 4'h0,32'h0,        8'd5},
    '{3'd3,1'b0,1'b1,2'd2,4'd8, 32'h0,        4'h0,32'hC0C1C2C3, 8'd5}, // R5
    '{3'd3,1'b0,1'b1,2'd2,4'd15,32'h0,        4'h0,32'hC0C1C2C3, 8'd5}, // R5
    '{3'd3,1'b0,1'b1,2'd2,4'd7, 32'h0,        4'h0,32'h0,        8'd5}, // R5 outside
    '{3'd4,1'b1,1'b0,2'd0,4'd0, 32'h11223344, 4'h0,32'h0,        8'd3},
    '{3'd2,1'b1,1'b1,2'd1,4'd5, 32'h80000201, 4'h0,32'h0,        8'd6},
    '{3'd3,1'b0,1'b1,2'd1,4'd0, 32'h0,        4'h0,32'h00000044, 8'd6}, // R6
    '{3'd3,1'b0,1'b1,2'd1,4'd1, 32'h0,        4'h0,32'h00003300, 8'd6}, // R6
    '{3'd3,1'b0,1'b1,2'd1,4'd7, 32'h0,        4'h0,32'h11000000, 8'd6}, // R6
    '{3'd3,1'b0,1'b1,2'd1,4'd2, 32'h0,        4'h0,32'h0,        8'd6}, // R6
    '{3'd4,1'b1,1'b0,2'd0,4'd0, 32'hAABBCCDD, 4'h0,32'h0,        8'd3},
    '{3'd2,1'b1,1'b1,2'd3,4'd0, 32'hFFFFFFFF, 4'h8,32'h0,        8'd8},
    '{3'd3,1'b0,1'b1,2'd3,4'd0, 32'h0,        4'h0,32'h00BBCCDD, 8'd8}, // R8 block
    '{3'd3,1'b0,1'b1,2'd3,4'd7, 32'h0,        4'h0,32'h00BBCCDD, 8'd8}, // R8 block
    '{3'd4,1'b0,1'b0,2'd0,4'd0, 32'h0F0F0F0F, 4'h0,32'h0,        8'd3},
    '{3'd1,1'b1,1'b0,2'd0,4'd0, 32'h0,        4'h0,32'h0,        8'd1},
    '{3'd2,1'b0,1'b0,2'd1,4'd2, 32'hFFFFFFFF, 4'h0,32'h0,        8'd2},
    '{3'd3,1'b0,1'b0,2'd1,4'd2, 32'h0,        4'h0,32'h0F0F0F0F, 8'd2}, // R2
    '{3'd2,1'b0,1'b1,2'd0,4'd0, 32'hFFFFFFFF, 4'h0,32'h0,        8'd1},
    '{3'd3,1'b0,1'b1,2'd0,4'd0, 32'h0,        4'h0,32'hFFFFFFFF, 8'd1}, // R1 other bank
    '{3'd4,1'b1,1'b0,2'd0,4'd0, 32'h12345678, 4'h0,32'h0,        8'd3},
    '{3'd2,1'b1,1'b0,2'd2,4'd9, 32'hFFFFFFFF, 4'h0,32'h0,        8'd7},
    '{3'd3,1'b0,1'b0,2'd2,4'd8, 32'h0,        4'h0,32'h02040608, 8'd7}, // R7 and R3
    '{3'd3,1'b0,1'b0,2'd2,4'd15,32'h0,        4'h0,32'h02040608, 8'd7}, // R7
    '{3'd1,1'b0,1'b0,2'd0,4'd0, 32'h0,        4'h0,32'h0,        8'd1},
    '{3'd2,1'b0,1'b0,2'd1,4'd2, 32'hFFFFFFFF, 4'h0,32'h0,        8'd1},
    '{3'd3,1'b0,1'b0,2'd1,4'd2, 32'h0,        4'h0,32'hFFFFFFFF, 8'd1}, // R1 disable
    '{3'd3,1'b0,1'b1,2'd3,4'd8, 32'h0,        4'h0,32'h0,        8'd5}  // R5 outside
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cmd_i = '0;
  logic        sf_i = 1'b0, bank_i = 1'b0;
  logic [1:0]  row_i = '0;
  logic [3:0]  col_i = '0;
  logic [31:0] dq_i = '0;
  logic [3:0]  byte_mask_i = '0;
  logic [31:0] rd_data_o;
  logic        rd_valid_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sgram_blockwr_top dut_i (
    .clk_i(clk), .rst_ni, .cmd_i, .sf_i, .bank_i, .row_i, .col_i,
    .dq_i, .byte_mask_i, .rd_data_o, .rd_valid_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic s, input logic b, input logic [1:0] r,
                       input logic [3:0] cl, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    cmd_i = c; sf_i = s; bank_i = b; row_i = r; col_i = cl; dq_i = d; byte_mask_i = m;
    @(posedge clk);
    #2;
  endtask

  task automatic rd_chk(input string tag, input logic b, input logic [1:0] r,
                        input logic [3:0] cl, input logic [31:0] exp);
    issue(3'd3, 1'b0, b, r, cl, 32'h0, 4'h0);
    chk(tag, rd_data_o, exp);
    chk({tag, " valid"}, {31'b0, rd_valid_o}, 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    chk("R9 rd_valid after reset", {31'b0, rd_valid_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].cmd, VEC[i].sf, VEC[i].bank, VEC[i].row, VEC[i].col, VEC[i].dq, VEC[i].bm);
      if (VEC[i].cmd == 3'd3)
        chk($sformatf("R%0d vec %0d", VEC[i].req, i), rd_data_o, VEC[i].exp);
      // R10 valid only after a read
      chk($sformatf("R10 valid vec %0d", i), {31'b0, rd_valid_o}, {31'b0, VEC[i].cmd == 3'd3});
    end

    // R10 idle cycle after read
    issue(3'd0, 1'b0, 1'b0, 2'd0, 4'd0, 32'h0, 4'h0);
    chk("R10 idle valid", {31'b0, rd_valid_o}, 32'h0);

    // R6 no select bits: block write leaves data intact
    issue(3'd2, 1'b0, 1'b1, 2'd0, 4'd1, 32'h5A5A5A5A, 4'h0);
    issue(3'd4, 1'b1, 1'b0, 2'd0, 4'd0, 32'hFFFFFFFF, 4'h0);
    issue(3'd2, 1'b1, 1'b1, 2'd0, 4'd0, 32'h0, 4'h0);
    rd_chk("R6 zero selects", 1'b1, 2'd0, 4'd1, 32'h5A5A5A5A);

    // R9 mid-run reset after enabling mask on bank 0
    issue(3'd4, 1'b0, 1'b0, 2'd0, 4'd0, 32'h0000FFFF, 4'h0);
    issue(3'd1, 1'b1, 1'b0, 2'd0, 4'd0, 32'h0, 4'h0);
    @(negedge clk);
    cmd_i = 3'd0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 rd_valid in reset", {31'b0, rd_valid_o}, 32'h0);
    rst_ni = 1'b1;
    rd_chk("R9 array cleared", 1'b1, 2'd0, 4'd1, 32'h0);
    issue(3'd2, 1'b0, 1'b0, 2'd1, 4'd2, 32'hFFFFFFFF, 4'h0);
    rd_chk("R9 enable cleared", 1'b0, 2'd1, 4'd2, 32'hFFFFFFFF);
    issue(3'd2, 1'b0, 1'b1, 2'd0, 4'd3, 32'hFFFFFFFF, 4'h0);
    issue(3'd2, 1'b1, 1'b1, 2'd0, 4'd0, 32'hFFFFFFFF, 4'h0);
    rd_chk("R9 color cleared", 1'b1, 2'd0, 4'd3, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule